// File: doc/BRIEF.md
# Output Stream Framing Pulse Generator

This block runs next to a streamed sample output and drives one marker bit that frames the stream. Upstream logic hands it one sample per clock with a valid strobe, a flag for the first sample of a buffer, a flag for the last sample of a message or buffer, and the index (0 or 1) of the buffer the sample came from. The block delays the sample path by two registers. The marker is built in the same register stage as the delayed sample, so it lines up with it. The block also needs to see a start one cycle ahead, so that it can raise a marker a clock before that sample appears.

Two modes share the one pin. In message mode the marker shows either the last sample of a message or the whole span of valid output. In record mode the samples fill two buffers in turn. The marker then shows either a buffer start (one clock early or on the first sample) or a level. The level is high through each whole buffer, or only through buffers of index 1. The block also reports the base address of the buffer the current output sample belongs to. It takes that address from one of two base inputs and clears the low two bits so the address is word aligned. A synchronous soft reset drops samples in flight and returns all state to idle.

Top module: `fpg_frame_marker`

## Requirements
- R1: A sample presented with `smp_valid_i` high appears on `data_o` with `valid_o` high exactly two clocks later. A cycle with `smp_valid_i` low gives `valid_o` low two clocks later.
- R2: With `mode_i`=0 (message) and `style_i[0]`=0, `marker_o` is high only in the output cycle of a valid sample that carried `smp_last_i`=1.
- R3: With `mode_i`=0 and `style_i[0]`=1, `marker_o` equals `valid_o` in every cycle.
- R4: With `mode_i`=1 (record) and `style_i`=0, `marker_o` pulses for one clock in the cycle just before a valid first-of-buffer sample shows on `data_o`.
- R5: With `mode_i`=1 and `style_i`=1, `marker_o` is high only in the output cycle of a valid first-of-buffer sample.
- R6: With `mode_i`=1 and `style_i`=2, `marker_o` is high from the output cycle of a first-of-buffer sample through the output cycle of that buffer's last sample. It stays high in gaps with no valid sample. A one-sample buffer, with both flags set, gives a single high cycle.
- R7: With `mode_i`=1 and `style_i`=3, `marker_o` behaves as in R6, but only for buffers whose first sample had `smp_buf_i`=1.
- R8: In the output cycle of each valid sample, `base_o` becomes `base0_i` (when `smp_buf_i`=0) or `base1_i` (when `smp_buf_i`=1), with bits [1:0] forced to zero. It holds its value through cycles with no valid output.
- R9: In the cycle after `soft_rst_i` is high, `valid_o`, `marker_o` and `base_o` are zero. Samples in flight, including one presented in the reset cycle, never reach the output. An open buffer is closed.
- R10: After `rst_ni` is released, `valid_o`, `marker_o`, `data_o` and `base_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous abort and clear |
| mode_i | input | 1 | 0 = message mode, 1 = record mode |
| style_i | input | 2 | Marker shape select within the mode |
| smp_valid_i | input | 1 | Sample valid strobe |
| smp_first_i | input | 1 | Sample is first of its buffer |
| smp_last_i | input | 1 | Sample ends the message or buffer |
| smp_buf_i | input | 1 | Buffer index of the sample |
| smp_data_i | input | DATA_W | Sample value |
| base0_i | input | ADDR_W | Base address of buffer 0 |
| base1_i | input | ADDR_W | Base address of buffer 1 |
| data_o | output | DATA_W | Delayed sample value |
| valid_o | output | 1 | Delayed sample valid |
| marker_o | output | 1 | Framing marker |
| base_o | output | ADDR_W | Aligned base of the current output buffer |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=24. These are narrower than the defaults, so the sample value and an odd base address can be recognised bit for bit on the outputs. Both base inputs have nonzero low bits, so each check of `base_o` also checks the alignment and which buffer was selected. One fixed stream is replayed under all six marker shapes. It holds a gap inside a buffer, a buffer of index 1 and a one-sample buffer, so a single expected pattern per shape covers early, concurrent and level timing.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic {
        MODE_MSG = 1'b0,
        MODE_REC = 1'b1
    } fpg_mode_e;

    localparam logic [1:0] STY_MSG_END   = 2'd0;
    localparam logic [1:0] STY_MSG_SPAN  = 2'd1;
    localparam logic [1:0] STY_REC_EARLY = 2'd0;
    localparam logic [1:0] STY_REC_FIRST = 2'd1;
    localparam logic [1:0] STY_REC_EACH  = 2'd2;
    localparam logic [1:0] STY_REC_SECND = 2'd3;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        logic buf_idx;
    } fpg_tag_t;

endpackage

// File: rtl/fpg_sample_pipe.sv
module fpg_sample_pipe
    import fpg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  fpg_tag_t          in_tag_i,
    input  logic [DATA_W-1:0] in_data_i,
    output fpg_tag_t          s1_tag_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);

    typedef struct packed {
        fpg_tag_t          s1_tag;
        logic [DATA_W-1:0] s1_data;
        logic              o_valid;
        logic [DATA_W-1:0] o_data;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.s1_tag  = in_tag_i;
        st_d.s1_data = in_data_i;
        st_d.o_valid = st_q.s1_tag.valid;
        if (st_q.s1_tag.valid) begin
            st_d.o_data = st_q.s1_data;
        end
        if (soft_rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_tag_o    = st_q.s1_tag;
    assign out_valid_o = st_q.o_valid;
    assign out_data_o  = st_q.o_data;

endmodule

// File: rtl/fpg_buf_track.sv
module fpg_buf_track
    import fpg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  fpg_tag_t          s1_tag_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    output logic              in_buf_o,
    output logic              in_buf2_o,
    output logic [ADDR_W-1:0] base_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    typedef struct packed {
        logic              open;
        logic              cur_buf;
        logic [ADDR_W-1:0] base;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    starts_w;
    logic    eff_buf_w;
    logic    in_buf_w;

    always_comb begin
        starts_w  = s1_tag_i.valid & s1_tag_i.first;
        in_buf_w  = s1_tag_i.valid ? (starts_w | st_q.open) : st_q.open;
        eff_buf_w = starts_w ? s1_tag_i.buf_idx : st_q.cur_buf;

        st_d         = st_q;
        st_d.cur_buf = eff_buf_w;
        if (s1_tag_i.valid) begin
            st_d.open = in_buf_w & ~s1_tag_i.last;
            st_d.base = (s1_tag_i.buf_idx ? base1_i : base0_i) & ALIGN_MASK;
        end
        if (soft_rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_buf_o  = in_buf_w;
    assign in_buf2_o = in_buf_w & eff_buf_w;
    assign base_o    = st_q.base;

    assert_base_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s1_tag_i.valid && !soft_rst_i) |=> $stable(base_o));

endmodule

// File: rtl/fpg_marker_shape.sv
module fpg_marker_shape
    import fpg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      soft_rst_i,
    input  fpg_mode_e mode_i,
    input  logic [1:0] style_i,
    input  logic      early_hit_i,
    input  logic      s1_valid_i,
    input  logic      s1_first_i,
    input  logic      s1_last_i,
    input  logic      in_buf_i,
    input  logic      in_buf2_i,
    output logic      marker_o
);

    logic marker_d, marker_q;

    always_comb begin
        marker_d = 1'b0;
        if (mode_i == MODE_MSG) begin
            if (style_i[0]) begin
                marker_d = s1_valid_i;
            end else begin
                marker_d = s1_valid_i & s1_last_i;
            end
        end else begin
            case (style_i)
                STY_REC_EARLY: marker_d = early_hit_i;
                STY_REC_FIRST: marker_d = s1_valid_i & s1_first_i;
                STY_REC_EACH:  marker_d = in_buf_i;
                default:       marker_d = in_buf2_i;
            endcase
        end
        if (soft_rst_i) begin
            marker_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            marker_q <= 1'b0;
        end else begin
            marker_q <= marker_d;
        end
    end

    assign marker_o = marker_q;

endmodule

// File: rtl/fpg_frame_marker.sv
module fpg_frame_marker
    import fpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              mode_i,
    input  logic [1:0]        style_i,
    input  logic              smp_valid_i,
    input  logic              smp_first_i,
    input  logic              smp_last_i,
    input  logic              smp_buf_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              marker_o,
    output logic [ADDR_W-1:0] base_o
);

    fpg_tag_t  in_tag_w;
    fpg_tag_t  s1_tag_w;
    fpg_mode_e mode_w;
    logic      in_buf_w;
    logic      in_buf2_w;
    logic      early_hit_w;

    assign in_tag_w    = '{valid: smp_valid_i, first: smp_first_i,
                           last: smp_last_i, buf_idx: smp_buf_i};
    assign mode_w      = fpg_mode_e'(mode_i);
    assign early_hit_w = smp_valid_i & smp_first_i;

    fpg_sample_pipe #(.DATA_W(DATA_W)) pipe_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .in_tag_i    (in_tag_w),
        .in_data_i   (smp_data_i),
        .s1_tag_o    (s1_tag_w),
        .out_valid_o (valid_o),
        .out_data_o  (data_o)
    );

    fpg_buf_track #(.ADDR_W(ADDR_W)) track_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .s1_tag_i   (s1_tag_w),
        .base0_i    (base0_i),
        .base1_i    (base1_i),
        .in_buf_o   (in_buf_w),
        .in_buf2_o  (in_buf2_w),
        .base_o     (base_o)
    );

    fpg_marker_shape shape_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .mode_i      (mode_w),
        .style_i     (style_i),
        .early_hit_i (early_hit_w),
        .s1_valid_i  (s1_tag_w.valid),
        .s1_first_i  (s1_tag_w.first),
        .s1_last_i   (s1_tag_w.last),
        .in_buf_i    (in_buf_w),
        .in_buf2_i   (in_buf2_w),
        .marker_o    (marker_o)
    );

    assert_pipe_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(soft_rst_i) |-> (valid_o == $past(s1_tag_w.valid)));

    assert_srst_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (!marker_o && !valid_o));

    assert_end_on_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 1'b0 && !style_i[0] && $stable(mode_i) && $stable(style_i) && marker_o)
            |-> valid_o);

    assert_span_eq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 1'b0 && style_i[0] && $stable(mode_i) && $stable(style_i))
            |-> (marker_o == valid_o));

    assert_early_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 1'b1 && style_i == 2'd0 && $stable(mode_i) && $stable(style_i)
            && marker_o && !soft_rst_i) |=> valid_o);

endmodule

// File: tb/fpg_frame_marker_tb.sv
`timescale 1ns/1ps
module fpg_frame_marker_tb_top;

    localparam int DW = 16;
    localparam int AW = 24;
    localparam logic [AW-1:0] B0 = 24'h12345F;
    localparam logic [AW-1:0] B1 = 24'hABCDE6;
    localparam logic [AW-1:0] B0_AL = 24'h12345C;
    localparam logic [AW-1:0] B1_AL = 24'hABCDE4;
    localparam logic [15:0] VALID_MASK = 16'h0758;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          mode = 1'b0;
    logic [1:0]    style = 2'd0;
    logic          v = 1'b0, f = 1'b0, l = 1'b0, b = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          vout, mk;
    logic [AW-1:0] bout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [AW-1:0] exp_base = '0;

    always #2 clk = ~clk;

    fpg_frame_marker #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
        .mode_i(mode), .style_i(style),
        .smp_valid_i(v), .smp_first_i(f), .smp_last_i(l), .smp_buf_i(b),
        .smp_data_i(din), .base0_i(B0), .base1_i(B1),
        .data_o(dout), .valid_o(vout), .marker_o(mk), .base_o(bout)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] stim(input int c);
        case (c)
            1: return 4'b1100;
            2: return 4'b1000;
            4: return 4'b1010;
            6: return 4'b1101;
            7: return 4'b1011;
            8: return 4'b1110;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic drive(input logic [3:0] s, input int c);
        {v, f, l, b} = s;
        din = DW'(16'hA000 + c);
    endtask

    // Replays the fixed stream; exp_mk holds the expected marker per iteration.
    task automatic run_shape(input logic m, input logic [1:0] st,
                             input logic [15:0] exp_mk, input string req);
        mode = m;
        style = st;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            chk(mk == exp_mk[c], req, 32'(mk), 32'(exp_mk[c]));
            chk(vout == VALID_MASK[c], "R1 valid", 32'(vout), 32'(VALID_MASK[c]));
            if (c >= 2 && VALID_MASK[c]) begin
                chk(dout == DW'(16'hA000 + c - 2), "R1 data", 32'(dout),
                    32'(16'hA000 + c - 2));
                exp_base = stim(c - 2)[0] ? B1_AL : B0_AL;
            end
            chk(bout == exp_base, "R8 base", 32'(bout), 32'(exp_base));
            drive(stim(c), c);
        end
    endtask

    task automatic t_reset_R10;
        @(negedge clk);
        chk(vout == 1'b0, "R10 valid", 32'(vout), 0);
        chk(mk == 1'b0, "R10 marker", 32'(mk), 0);
        chk(dout == '0, "R10 data", 32'(dout), 0);
        chk(bout == '0, "R10 base", 32'(bout), 0);
    endtask

    task automatic t_soft_R9;
        mode = 1'b1;
        style = 2'd2;
        @(negedge clk); drive(4'b1100, 0);
        @(negedge clk); drive(4'b1000, 1);
        @(negedge clk);
        chk(vout == 1'b1, "R9 pre valid", 32'(vout), 1);
        chk(mk == 1'b1, "R9 pre marker", 32'(mk), 1);
        drive(4'b1000, 2);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(vout == 1'b0, "R9 valid cleared", 32'(vout), 0);
        chk(mk == 1'b0, "R9 marker cleared", 32'(mk), 0);
        chk(bout == '0, "R9 base cleared", 32'(bout), 0);
        drive(4'b1001, 3);
        @(negedge clk);
        chk(vout == 1'b0, "R9 dropped sample", 32'(vout), 0);
        drive(4'b0000, 4);
        @(negedge clk);
        chk(vout == 1'b1, "R9 later valid", 32'(vout), 1);
        chk(dout == DW'(16'hA003), "R9 later data", 32'(dout), 32'hA003);
        chk(mk == 1'b0, "R9 buffer closed", 32'(mk), 0);
        chk(bout == B1_AL, "R9 base after", 32'(bout), 32'(B1_AL));
        exp_base = B1_AL;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R10();
        run_shape(1'b0, 2'd0, 16'h0640, "R2 message end pulse");
        run_shape(1'b0, 2'd1, 16'h0758, "R3 message span level");
        run_shape(1'b1, 2'd0, 16'h0284, "R4 record early pulse");
        run_shape(1'b1, 2'd1, 16'h0508, "R5 record first pulse");
        run_shape(1'b1, 2'd2, 16'h0778, "R6 record buffer level");
        run_shape(1'b1, 2'd3, 16'h0300, "R7 record second-buffer level");
        t_soft_R9();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule